// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This unit keeps the program counter and the active-thread mask for every warp on a streaming core. It also keeps each warp's reconvergence stack. All lanes of a warp issue the same instruction in lockstep, and the mask chooses which of them may commit results. When a conditional branch splits the active lanes, the unit first steers the warp to the taken target with only the taken lanes enabled. It records the remaining lanes as a pending path. When the first path reaches the reconvergence PC, the warp moves to the fall-through path with the complementary lanes. When that second path also arrives, the unit restores the mask the warp held before the branch.

A warp's lane membership is set when the warp is launched and stays the same until the next launch. Only the active mask changes. Each warp has its own PC, mask and stack, so warps at different PCs do not interfere. One event enters per cycle: launch, branch or step. A step is the fetch logic reporting the PC the warp has reached. The unit answers one cycle later on registered outputs with the warp's new PC and mask.

Top module: `simt_div_unit`

## Requirements
- R1: After reset, out_valid and out_ovf are 0, and every warp has mask 0 and an empty stack. A step on a warp that was never launched returns the stepped PC with mask 0.
- R2: A launch (ev_op=1) sets the warp's PC to ev_pc and its mask to ev_mask, and clears its stack.
- R3: A step (ev_op=3) whose PC is not the reconvergence PC of the warp's top stack entry, or that happens with an empty stack, moves the PC to ev_pc and keeps the mask.
- R4: A branch (ev_op=2) where every active lane has taken=1 goes to the target PC. One where every active lane has taken=0 goes to the fall-through PC. Either way the mask is kept, nothing is pushed, and taken bits of inactive lanes have no effect.
- R5: A branch whose active lanes disagree pushes an entry and goes to the target PC, with the mask set to the active lanes whose taken bit is 1.
- R6: The first step that matches the top entry's reconvergence PC goes to the fall-through PC, with the mask set to the active lanes that did not take the branch. The entry stays on the stack.
- R7: The second matching step goes to the reconvergence PC, restores the mask held before the branch, and pops the entry. Each event performs at most one stack action.
- R8: A diverging branch when the warp already holds DEPTH entries raises out_ovf for that event. The PC, mask and stack of the warp are left unchanged.
- R9: An event on one warp leaves the PC, mask and stack of every other warp unchanged.
- R10: out_valid is 1 exactly one cycle after each event with ev_op not 0, and out_warp then echoes ev_warp.
- R11: out_mask never holds a lane outside the mask given at the warp's last launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_op | input | 2 | Event: 0 none, 1 launch, 2 branch, 3 step |
| ev_warp | input | $clog2(NWARPS) | Warp the event applies to |
| ev_pc | input | PC_W | Launch PC, or PC reached on a step |
| ev_mask | input | LANES | Lane membership for a launch |
| ev_taken | input | LANES | Per-lane branch outcome |
| ev_tgt_pc | input | PC_W | Branch target PC |
| ev_fall_pc | input | PC_W | Branch fall-through PC |
| ev_rcv_pc | input | PC_W | Branch reconvergence PC |
| out_valid | output | 1 | Result of the previous cycle's event |
| out_warp | output | $clog2(NWARPS) | Warp of the result |
| out_pc | output | PC_W | Warp's next PC |
| out_mask | output | LANES | Warp's active mask |
| out_ovf | output | 1 | Divergence stack overflow on this event |

## Verification
The bench builds the unit with 8 lanes, 2 warps, a stack depth of 2 and 16-bit PCs. With 8 lanes, random taken vectors fall on both sides of the uniform/split boundary often. A depth of 2 makes overflow reachable after only two nested splits. Two warps let events on different warps interleave on consecutive cycles, which exercises warp independence while one warp is diverged.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LAUNCH = 2'd1,
    OP_BRANCH = 2'd2,
    OP_STEP   = 2'd3
  } ev_op_e;

  typedef enum logic [1:0] {
    SPL_ALL_NT = 2'd0,
    SPL_ALL_TK = 2'd1,
    SPL_BOTH   = 2'd2
  } split_e;

endpackage

// File: rtl/simt_div_classify.sv
module simt_div_classify
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] act_mask,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask,
  output split_e           kind
);

  always_comb begin
    tk_mask = act_mask & taken;
    nt_mask = act_mask & ~taken;
    if (tk_mask == '0)      kind = SPL_ALL_NT;
    else if (nt_mask == '0) kind = SPL_ALL_TK;
    else                    kind = SPL_BOTH;
  end

endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
  parameter int ENTRIES = 16,
  parameter int ENT_W   = 129,
  parameter int AW      = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ENT_W-1:0] rdata
);

  logic [ENT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/simt_div_next.sv
module simt_div_next
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 4,
  parameter int SP_W  = 3
) (
  input  ev_op_e           op,
  input  split_e           kind,
  input  logic [LANES-1:0] tk_mask,
  input  logic [LANES-1:0] nt_mask,
  input  logic [PC_W-1:0]  ev_pc,
  input  logic [LANES-1:0] ev_mask,
  input  logic [PC_W-1:0]  ev_tgt_pc,
  input  logic [PC_W-1:0]  ev_fall_pc,
  input  logic [PC_W-1:0]  ev_rcv_pc,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [LANES-1:0] cur_mask,
  input  logic [SP_W-1:0]  cur_sp,
  input  logic [PC_W-1:0]  top_rcv,
  input  logic [PC_W-1:0]  top_fall,
  input  logic [LANES-1:0] top_pend,
  input  logic [LANES-1:0] top_full,
  input  logic             top_second,
  output logic [PC_W-1:0]  nxt_pc,
  output logic [LANES-1:0] nxt_mask,
  output logic [SP_W-1:0]  nxt_sp,
  output logic             ovf,
  output logic             st_we,
  output logic             st_at_top,
  output logic [PC_W-1:0]  w_rcv,
  output logic [PC_W-1:0]  w_fall,
  output logic [LANES-1:0] w_pend,
  output logic [LANES-1:0] w_full,
  output logic             w_second
);

  localparam logic [SP_W-1:0] FULL_SP = SP_W'(DEPTH);

  logic rcv_hit;
  assign rcv_hit = (cur_sp != '0) && (ev_pc == top_rcv);

  always_comb begin
    nxt_pc    = cur_pc;
    nxt_mask  = cur_mask;
    nxt_sp    = cur_sp;
    ovf       = 1'b0;
    st_we     = 1'b0;
    st_at_top = 1'b0;
    w_rcv     = ev_rcv_pc;
    w_fall    = ev_fall_pc;
    w_pend    = nt_mask;
    w_full    = cur_mask;
    w_second  = 1'b0;
    unique case (op)
      OP_LAUNCH: begin
        nxt_pc   = ev_pc;
        nxt_mask = ev_mask;
        nxt_sp   = '0;
      end
      OP_BRANCH: begin
        unique case (kind)
          SPL_ALL_NT: nxt_pc = ev_fall_pc;
          SPL_ALL_TK: nxt_pc = ev_tgt_pc;
          default: begin
            if (cur_sp == FULL_SP) begin
              ovf = 1'b1;
            end else begin
              st_we    = 1'b1;
              nxt_pc   = ev_tgt_pc;
              nxt_mask = tk_mask;
              nxt_sp   = cur_sp + 1'b1;
            end
          end
        endcase
      end
      OP_STEP: begin
        if (rcv_hit && !top_second) begin
          nxt_pc    = top_fall;
          nxt_mask  = top_pend;
          st_we     = 1'b1;
          st_at_top = 1'b1;
          w_rcv     = top_rcv;
          w_fall    = top_fall;
          w_pend    = top_pend;
          w_full    = top_full;
          w_second  = 1'b1;
        end else if (rcv_hit) begin
          nxt_pc   = top_rcv;
          nxt_mask = top_full;
          nxt_sp   = cur_sp - 1'b1;
        end else begin
          nxt_pc = ev_pc;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/simt_div_unit.sv
module simt_div_unit
  import simt_div_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int PC_W   = 32,
  parameter int NWARPS = 4,
  parameter int DEPTH  = 4,
  localparam int WW    = $clog2(NWARPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ev_op,
  input  logic [WW-1:0]    ev_warp,
  input  logic [PC_W-1:0]  ev_pc,
  input  logic [LANES-1:0] ev_mask,
  input  logic [LANES-1:0] ev_taken,
  input  logic [PC_W-1:0]  ev_tgt_pc,
  input  logic [PC_W-1:0]  ev_fall_pc,
  input  logic [PC_W-1:0]  ev_rcv_pc,
  output logic             out_valid,
  output logic [WW-1:0]    out_warp,
  output logic [PC_W-1:0]  out_pc,
  output logic [LANES-1:0] out_mask,
  output logic             out_ovf
);

  localparam int SP_W    = $clog2(DEPTH + 1);
  localparam int ENTRIES = NWARPS * DEPTH;
  localparam int AW      = $clog2(ENTRIES);
  localparam int ENT_W   = 2 * PC_W + 2 * LANES + 1;

  logic [PC_W-1:0]  pc_q   [NWARPS];
  logic [LANES-1:0] mask_q [NWARPS];
  logic [SP_W-1:0]  sp_q   [NWARPS];

  ev_op_e           op;
  logic [PC_W-1:0]  cur_pc;
  logic [LANES-1:0] cur_mask;
  logic [SP_W-1:0]  cur_sp;

  assign op       = ev_op_e'(ev_op);
  assign cur_pc   = pc_q[ev_warp];
  assign cur_mask = mask_q[ev_warp];
  assign cur_sp   = sp_q[ev_warp];

  logic [LANES-1:0] tk_mask, nt_mask;
  split_e           kind;

  simt_div_classify #(.LANES(LANES)) cls_i (
    .act_mask (cur_mask),
    .taken    (ev_taken),
    .tk_mask  (tk_mask),
    .nt_mask  (nt_mask),
    .kind     (kind)
  );

  logic [AW-1:0]    base_addr, top_addr, push_addr, st_waddr;
  logic [ENT_W-1:0] st_wdata, st_rdata;
  logic [PC_W-1:0]  top_rcv, top_fall;
  logic [LANES-1:0] top_pend, top_full;
  logic             top_second;

  assign base_addr = AW'(ev_warp) * AW'(DEPTH);
  assign top_addr  = base_addr + AW'(cur_sp) - 1'b1;
  assign push_addr = base_addr + AW'(cur_sp);

  assign {top_second, top_full, top_pend, top_fall, top_rcv} = st_rdata;

  logic [PC_W-1:0]  nxt_pc, w_rcv, w_fall;
  logic [LANES-1:0] nxt_mask, w_pend, w_full;
  logic [SP_W-1:0]  nxt_sp;
  logic             ovf, st_we, st_at_top, w_second;

  simt_div_next #(
    .LANES (LANES),
    .PC_W  (PC_W),
    .DEPTH (DEPTH),
    .SP_W  (SP_W)
  ) nxt_i (
    .op         (op),
    .kind       (kind),
    .tk_mask    (tk_mask),
    .nt_mask    (nt_mask),
    .ev_pc      (ev_pc),
    .ev_mask    (ev_mask),
    .ev_tgt_pc  (ev_tgt_pc),
    .ev_fall_pc (ev_fall_pc),
    .ev_rcv_pc  (ev_rcv_pc),
    .cur_pc     (cur_pc),
    .cur_mask   (cur_mask),
    .cur_sp     (cur_sp),
    .top_rcv    (top_rcv),
    .top_fall   (top_fall),
    .top_pend   (top_pend),
    .top_full   (top_full),
    .top_second (top_second),
    .nxt_pc     (nxt_pc),
    .nxt_mask   (nxt_mask),
    .nxt_sp     (nxt_sp),
    .ovf        (ovf),
    .st_we      (st_we),
    .st_at_top  (st_at_top),
    .w_rcv      (w_rcv),
    .w_fall     (w_fall),
    .w_pend     (w_pend),
    .w_full     (w_full),
    .w_second   (w_second)
  );

  assign st_waddr = st_at_top ? top_addr : push_addr;
  assign st_wdata = {w_second, w_full, w_pend, w_fall, w_rcv};

  simt_div_stack #(
    .ENTRIES (ENTRIES),
    .ENT_W   (ENT_W),
    .AW      (AW)
  ) stk_i (
    .clk   (clk),
    .we    (st_we && !rst),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (top_addr),
    .rdata (st_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWARPS; i++) begin
        pc_q[i]   <= '0;
        mask_q[i] <= '0;
        sp_q[i]   <= '0;
      end
    end else if (op != OP_NONE) begin
      pc_q[ev_warp]   <= nxt_pc;
      mask_q[ev_warp] <= nxt_mask;
      sp_q[ev_warp]   <= nxt_sp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_warp  <= '0;
      out_pc    <= '0;
      out_mask  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= (op != OP_NONE);
      out_warp  <= ev_warp;
      out_pc    <= nxt_pc;
      out_mask  <= nxt_mask;
      out_ovf   <= ovf;
    end
  end

endmodule

// File: rtl/simt_div_unit_chk.sv
module simt_div_unit_chk #(
  parameter int LANES  = 32,
  parameter int PC_W   = 32,
  parameter int NWARPS = 4,
  parameter int WW     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       ev_op,
  input logic [WW-1:0]    ev_warp,
  input logic [LANES-1:0] ev_mask,
  input logic [LANES-1:0] ev_taken,
  input logic [PC_W-1:0]  ev_tgt_pc,
  input logic [PC_W-1:0]  cur_pc,
  input logic [LANES-1:0] cur_mask,
  input logic             out_valid,
  input logic [WW-1:0]    out_warp,
  input logic [PC_W-1:0]  out_pc,
  input logic [LANES-1:0] out_mask,
  input logic             out_ovf
);

  logic [LANES-1:0] member [NWARPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWARPS; i++) member[i] <= '0;
    end else if (ev_op == 2'd1) begin
      member[ev_warp] <= ev_mask;
    end
  end

  AST_OUT_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == ($past(ev_op) != 2'd0))); // R10
  AST_WARP_ECHO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst)) |-> (out_warp == $past(ev_warp))); // R10
  AST_MASK_IN_WARP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_mask & ~member[out_warp]) == '0)); // R11
  AST_UNIFORM_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ev_op == 2'd2 &&
      (((ev_taken & cur_mask) == '0) || ((cur_mask & ~ev_taken) == '0))))
    |-> (out_mask == $past(cur_mask) && !out_ovf)); // R4
  AST_SPLIT_TAKEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_ovf && $past(ev_op == 2'd2 &&
      ((ev_taken & cur_mask) != '0) && ((cur_mask & ~ev_taken) != '0)))
    |-> (out_pc == $past(ev_tgt_pc) && out_mask == $past(ev_taken & cur_mask))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> ($past(ev_op) == 2'd2 && out_pc == $past(cur_pc)
                 && out_mask == $past(cur_mask))); // R8

endmodule

bind simt_div_unit simt_div_unit_chk #(
  .LANES  (LANES),
  .PC_W   (PC_W),
  .NWARPS (NWARPS),
  .WW     (WW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ev_op     (ev_op),
  .ev_warp   (ev_warp),
  .ev_mask   (ev_mask),
  .ev_taken  (ev_taken),
  .ev_tgt_pc (ev_tgt_pc),
  .cur_pc    (cur_pc),
  .cur_mask  (cur_mask),
  .out_valid (out_valid),
  .out_warp  (out_warp),
  .out_pc    (out_pc),
  .out_mask  (out_mask),
  .out_ovf   (out_ovf)
);

// File: tb/simt_div_unit_tb_top.sv
`timescale 1ns/1ps
module simt_div_unit_tb_top;

  localparam int LANES  = 8;
  localparam int PC_W   = 16;
  localparam int NWARPS = 2;
  localparam int DEPTH  = 2;
  localparam int WW     = $clog2(NWARPS);

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       ev_op;
  logic [WW-1:0]    ev_warp;
  logic [PC_W-1:0]  ev_pc, ev_tgt_pc, ev_fall_pc, ev_rcv_pc;
  logic [LANES-1:0] ev_mask, ev_taken;
  logic             out_valid, out_ovf;
  logic [WW-1:0]    out_warp;
  logic [PC_W-1:0]  out_pc;
  logic [LANES-1:0] out_mask;

  always #10 clk = ~clk;

  simt_div_unit #(
    .LANES (LANES), .PC_W (PC_W), .NWARPS (NWARPS), .DEPTH (DEPTH)
  ) dut_i (
    .clk (clk), .rst (rst), .ev_op (ev_op), .ev_warp (ev_warp),
    .ev_pc (ev_pc), .ev_mask (ev_mask), .ev_taken (ev_taken),
    .ev_tgt_pc (ev_tgt_pc), .ev_fall_pc (ev_fall_pc), .ev_rcv_pc (ev_rcv_pc),
    .out_valid (out_valid), .out_warp (out_warp), .out_pc (out_pc),
    .out_mask (out_mask), .out_ovf (out_ovf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  logic [PC_W-1:0]  m_pc     [NWARPS];
  logic [LANES-1:0] m_mask   [NWARPS];
  logic [LANES-1:0] m_member [NWARPS];
  int               m_sp     [NWARPS];
  logic [PC_W-1:0]  m_rcv    [NWARPS][DEPTH];
  logic [PC_W-1:0]  m_fall   [NWARPS][DEPTH];
  logic [LANES-1:0] m_pend   [NWARPS][DEPTH];
  logic [LANES-1:0] m_full   [NWARPS][DEPTH];
  bit               m_second [NWARPS][DEPTH];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < NWARPS; w++) begin
      m_pc[w] = '0; m_mask[w] = '0; m_member[w] = '0; m_sp[w] = 0;
    end
  endtask

  // applies one event to the model; returns expected ovf and the requirement tag
  function automatic string model_apply(input logic [1:0] op, input int w,
      input logic [LANES-1:0] tk_in, input logic [PC_W-1:0] tgt, fall, rcv, pc,
      input logic [LANES-1:0] msk, output bit ovf);
    logic [LANES-1:0] tk, nt;
    int s;
    ovf = 0;
    tk = tk_in & m_mask[w];
    nt = m_mask[w] & ~tk_in;
    s = m_sp[w];
    case (op)
      2'd1: begin
        m_pc[w] = pc; m_mask[w] = msk; m_member[w] = msk; m_sp[w] = 0;
        return "R2";
      end
      2'd2: begin
        if (tk == '0) begin m_pc[w] = fall; return "R4"; end
        if (nt == '0) begin m_pc[w] = tgt; return "R4"; end
        if (s == DEPTH) begin ovf = 1; return "R8"; end
        m_rcv[w][s] = rcv; m_fall[w][s] = fall; m_pend[w][s] = nt;
        m_full[w][s] = m_mask[w]; m_second[w][s] = 0;
        m_sp[w] = s + 1; m_pc[w] = tgt; m_mask[w] = tk;
        return "R5";
      end
      default: begin
        if (s > 0 && pc == m_rcv[w][s-1]) begin
          if (!m_second[w][s-1]) begin
            m_second[w][s-1] = 1;
            m_pc[w] = m_fall[w][s-1]; m_mask[w] = m_pend[w][s-1];
            return "R6";
          end
          m_pc[w] = m_rcv[w][s-1]; m_mask[w] = m_full[w][s-1];
          m_sp[w] = s - 1;
          return "R7";
        end
        m_pc[w] = pc;
        return "R3";
      end
    endcase
  endfunction

  task automatic do_event(input logic [1:0] op, input int w,
      input logic [LANES-1:0] tk, input logic [PC_W-1:0] tgt, fall, rcv, pc,
      input logic [LANES-1:0] msk, input string tag);
    string req;
    bit exp_ovf;
    @(negedge clk);
    ev_op = op; ev_warp = WW'(w); ev_taken = tk; ev_tgt_pc = tgt;
    ev_fall_pc = fall; ev_rcv_pc = rcv; ev_pc = pc; ev_mask = msk;
    req = model_apply(op, w, tk, tgt, fall, rcv, pc, msk, exp_ovf);
    if (tag != "") req = tag;
    @(negedge clk);
    ev_op = 2'd0;
    check("R10 valid", 64'(out_valid), 64'd1);
    check("R10 warp", 64'(out_warp), 64'(w));
    check({req, " pc"}, 64'(out_pc), 64'(m_pc[w]));
    check({req, " mask"}, 64'(out_mask), 64'(m_mask[w]));
    check({req, " ovf"}, 64'(out_ovf), 64'(exp_ovf));
    check("R11 member", 64'(out_mask & ~m_member[w]), 64'd0);
    @(negedge clk);
    check("R10 idle", 64'(out_valid), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    rst = 1'b1; ev_op = 2'd0; ev_warp = '0; ev_pc = '0; ev_mask = '0;
    ev_taken = '0; ev_tgt_pc = '0; ev_fall_pc = '0; ev_rcv_pc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 ovf", 64'(out_ovf), 64'd0);
    // R1: warp never launched has mask 0
    do_event(2'd3, 1, '0, '0, '0, '0, 16'h0010, '0, "R1");
    do_event(2'd1, 0, '0, '0, '0, '0, 16'h0100, 8'hFF, "");
    do_event(2'd2, 0, 8'hFF, 16'h0120, 16'h0104, 16'h0140, '0, '0, "");
    do_event(2'd1, 1, '0, '0, '0, '0, 16'h0200, 8'h0F, "");
    // R4: taken bits only on inactive lanes
    do_event(2'd2, 1, 8'hF0, 16'h0220, 16'h0204, 16'h0240, '0, '0, "R4");
    do_event(2'd2, 0, 8'h3C, 16'h0300, 16'h0400, 16'h0500, '0, '0, "");
    // R9: other warp unaffected, even at the same PC as warp 0's reconvergence
    do_event(2'd3, 1, '0, '0, '0, '0, 16'h0500, '0, "R9");
    do_event(2'd2, 0, 8'h0C, 16'h0310, 16'h0320, 16'h0330, '0, '0, "");
    do_event(2'd2, 0, 8'h04, 16'h0700, 16'h0710, 16'h0720, '0, '0, "");
    do_event(2'd3, 0, '0, '0, '0, '0, 16'h0330, '0, "");
    do_event(2'd3, 0, '0, '0, '0, '0, 16'h0330, '0, "");
    do_event(2'd3, 0, '0, '0, '0, '0, 16'h0500, '0, "");
    do_event(2'd3, 0, '0, '0, '0, '0, 16'h0321, '0, "");
    do_event(2'd3, 0, '0, '0, '0, '0, 16'h0500, '0, "");
    do_event(2'd3, 1, '0, '0, '0, '0, 16'h0504, '0, "R9");

    for (int k = 0; k < 1500; k++) begin
      int w, sel, tsel;
      logic [LANES-1:0] tk, msk;
      logic [PC_W-1:0] pc;
      w = int'($urandom_range(NWARPS - 1));
      sel = int'($urandom_range(99));
      tsel = int'($urandom_range(2));
      tk = (tsel == 0) ? '1 : (tsel == 1) ? '0 : LANES'($urandom);
      msk = LANES'($urandom);
      pc = PC_W'($urandom);
      if (sel < 6) begin
        do_event(2'd1, w, '0, '0, '0, '0, pc, msk, "");
      end else if (sel < 50) begin
        do_event(2'd2, w, tk, PC_W'($urandom), PC_W'($urandom),
                 PC_W'($urandom), '0, '0, "");
      end else begin
        if (m_sp[w] > 0 && $urandom_range(9) < 7) pc = m_rcv[w][m_sp[w]-1];
        do_event(2'd3, w, '0, '0, '0, '0, pc, '0, "");
      end
    end
    finish_run();
  end

endmodule